// File: doc/BRIEF.md
# Programming Session Entry Controller

This block decides whether the device is in serial programming mode. It watches the power-on-reset signal, the active-low reset pin and two configuration fuse bits. From these it drives two outputs. One is a programming-mode flag that lets the serial command engine act. The other is a core-hold signal that keeps the processor in reset while a session runs.

Entry is judged at the end of power-on reset. If the reset pin is low when power-on reset ends, a session starts. A session can also start later, during any reset period, but only when the programming-enable fuse is set and the reset pin is still working as a reset. Whichever way a session starts, it ends when the reset pin goes high. The block then locks, and refuses any further session until power-on reset is asserted again.

The reset pin is asynchronous to the block clock. It passes through a synchronizer before any decision uses it. Every output change caused by the pin therefore follows the synchronized level. The block has no data stream, so every pin is a plain level signal.

Top module: `prog_entry_ctrl`

## Requirements
- R1: While `por_i` is 1, `prog_mode_o` is 0 and `core_hold_o` is 1, and both outputs reach these values at once, without waiting for a clock edge.
- R2: If `rst_pin_n_i` is 0 when `por_i` falls, `prog_mode_o` becomes 1 after the third rising clock edge following the fall, whatever the value of `pin_rst_dis_i`.
- R3: If `rst_pin_n_i` is 1 when `por_i` falls, `prog_mode_o` stays 0. The block is then in normal operation.
- R4: During a session, a rise of `rst_pin_n_i` clears `prog_mode_o` after the third rising clock edge following the rise.
- R5: Once a session has ended, `prog_mode_o` stays 0 until `por_i` is asserted again, even if `rst_pin_n_i` goes low with `isp_any_en_i`=1.
- R6: In normal operation with `isp_any_en_i`=1 and `pin_rst_dis_i`=0, a low level on `rst_pin_n_i` sets `prog_mode_o` after the third rising edge following the fall.
- R7: In normal operation with `isp_any_en_i`=0, a low `rst_pin_n_i` never sets `prog_mode_o`.
- R8: In normal operation with `pin_rst_dis_i`=1, a low `rst_pin_n_i` neither sets `prog_mode_o` nor raises `core_hold_o`.
- R9: `core_hold_o` is 1 throughout the settle window after power-on reset and throughout a session. In normal or locked operation with `pin_rst_dis_i`=0, it follows the inverted pin level two rising edges after the pin changes.
- R10: Asserting `por_i` again clears the lock, so a new session can start at the end of that power-on reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| por_i | input | 1 | Power-on reset, active high, asynchronous; its fall marks completion |
| rst_pin_n_i | input | 1 | Reset pin level, active low, asynchronous |
| isp_any_en_i | input | 1 | Fuse: allow entry in any reset period, not only at power-on |
| pin_rst_dis_i | input | 1 | Fuse: reset pin serves as I/O after power-up |
| prog_mode_o | output | 1 | Programming session active; gates the serial command engine |
| core_hold_o | output | 1 | Holds the processor in reset |

## Verification
Every pin-driven result has a fixed delay. A change on the reset pin reaches `core_hold_o` after two rising edges. The same change reaches `prog_mode_o` after three rising edges, and so does the fall of power-on reset. A change on `por_i` itself acts at once. Each scenario task drives its inputs on a falling edge and then counts falling edges. It samples once on the falling edge just before the output is due, expecting the old value, and once on the falling edge just after, expecting the new one. This proves both the delay and the final value. The no-entry cases hold the pin low for several cycles past the entry delay and then check both outputs.

// File: rtl/prog_entry_pkg.sv
package prog_entry_pkg;
  typedef enum logic [1:0] {
    ST_POR_WAIT = 2'd0,
    ST_NORMAL   = 2'd1,
    ST_ACTIVE   = 2'd2,
    ST_LOCKED   = 2'd3
  } sess_state_e;
endpackage

// File: rtl/prog_pin_sync.sv
module prog_pin_sync #(
  parameter int STAGES = 2,
  parameter bit RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic arst_i,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or posedge arst_i) begin
    if (arst_i) chain_q <= {STAGES{RST_VAL}};
    else        chain_q <= {chain_q[STAGES-2:0], d_i};
  end

  assign q_o = chain_q[STAGES-1];

  // R9
  sync_hold_chk: assert property (@(posedge clk) disable iff (arst_i)
    ($past(chain_q[STAGES-2]) == chain_q[STAGES-1]));
endmodule

// File: rtl/prog_entry_fsm.sv
module prog_entry_fsm
  import prog_entry_pkg::*;
#(
  parameter int SETTLE = 2
) (
  input  logic clk,
  input  logic por_i,
  input  logic pin_low_i,
  input  logic isp_any_en_i,
  input  logic pin_rst_dis_i,
  output logic prog_mode_o,
  output logic core_hold_o
);
  localparam int CW = $clog2(SETTLE + 1);

  sess_state_e st_q, st_d;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or posedge por_i) begin
    if (por_i) begin
      st_q  <= ST_POR_WAIT;
      cnt_q <= '0;
    end else begin
      st_q <= st_d;
      if (st_q == ST_POR_WAIT && cnt_q != CW'(SETTLE)) cnt_q <= cnt_q + 1'b1;
    end
  end

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_POR_WAIT: if (cnt_q == CW'(SETTLE)) st_d = pin_low_i ? ST_ACTIVE : ST_NORMAL;
      ST_NORMAL:   if (pin_low_i && isp_any_en_i && !pin_rst_dis_i) st_d = ST_ACTIVE;
      ST_ACTIVE:   if (!pin_low_i) st_d = ST_LOCKED;
      ST_LOCKED:   st_d = ST_LOCKED;
      default:     st_d = ST_POR_WAIT;
    endcase
  end

  assign prog_mode_o = (st_q == ST_ACTIVE);
  assign core_hold_o = (st_q == ST_POR_WAIT) || (st_q == ST_ACTIVE) ||
                       (pin_low_i && !pin_rst_dis_i);

  // R1
  por_idle_chk: assert property (@(posedge clk) por_i |-> (!prog_mode_o && core_hold_o));
  // R4
  exit_chk: assert property (@(posedge clk) disable iff (por_i)
    (prog_mode_o && !pin_low_i) |=> !prog_mode_o);
  // R5
  lock_chk: assert property (@(posedge clk) disable iff (por_i)
    (st_q == ST_LOCKED) |=> (st_q == ST_LOCKED && !prog_mode_o));
  // R7
  no_fuse_chk: assert property (@(posedge clk) disable iff (por_i)
    (st_q == ST_NORMAL && !isp_any_en_i) |=> !prog_mode_o);
  // R8
  pin_io_chk: assert property (@(posedge clk) disable iff (por_i)
    (st_q == ST_NORMAL && pin_rst_dis_i) |=> !prog_mode_o);
  // R9
  hold_in_sess_chk: assert property (@(posedge clk) disable iff (por_i)
    prog_mode_o |-> core_hold_o);
endmodule

// File: rtl/prog_entry_ctrl.sv
module prog_entry_ctrl #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic por_i,
  input  logic rst_pin_n_i,
  input  logic isp_any_en_i,
  input  logic pin_rst_dis_i,
  output logic prog_mode_o,
  output logic core_hold_o
);
  localparam int SETTLE = SYNC_STAGES;

  logic pin_n_s;

  prog_pin_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
    .clk    (clk),
    .arst_i (por_i),
    .d_i    (rst_pin_n_i),
    .q_o    (pin_n_s)
  );

  prog_entry_fsm #(.SETTLE(SETTLE)) u_fsm (
    .clk           (clk),
    .por_i         (por_i),
    .pin_low_i     (!pin_n_s),
    .isp_any_en_i  (isp_any_en_i),
    .pin_rst_dis_i (pin_rst_dis_i),
    .prog_mode_o   (prog_mode_o),
    .core_hold_o   (core_hold_o)
  );
endmodule

// File: tb/prog_entry_ctrl_tb.sv
module prog_entry_ctrl_tb_top;
  logic clk = 1'b0;
  logic por = 1'b1, pin_n = 1'b1, isp_en = 1'b0, pin_dis = 1'b0;
  logic prog, hold;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  prog_entry_ctrl dut_i (
    .clk(clk), .por_i(por), .rst_pin_n_i(pin_n), .isp_any_en_i(isp_en),
    .pin_rst_dis_i(pin_dis), .prog_mode_o(prog), .core_hold_o(hold)
  );

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // Power-on reset with the pin at a given level; after return, por fell at the current negedge
  task automatic power_up(input logic pin_lvl);
    @(negedge clk);
    por = 1'b1;
    pin_n = pin_lvl;
    #1;
    chk("R1 prog during por", prog, 1'b0);
    chk("R1 hold during por", hold, 1'b1);
    wait_n(3);
    por = 1'b0;
  endtask

  task automatic t_por_entry(input logic dis);
    pin_dis = dis; isp_en = 1'b0;
    power_up(1'b0);
    wait_n(1); chk("R9 hold in settle", hold, 1'b1);
    wait_n(1); chk("R2 prog before third edge", prog, 1'b0);
    wait_n(1); chk("R2 prog after third edge", prog, 1'b1);
    chk("R9 hold in session", hold, 1'b1);
  endtask

  task automatic t_exit;
    pin_n = 1'b1;
    wait_n(2); chk("R4 prog before third edge", prog, 1'b1);
    wait_n(1); chk("R4 prog after third edge", prog, 1'b0);
    chk("R9 hold after exit pin high", hold, 1'b0);
  endtask

  task automatic t_locked;
    isp_en = 1'b1; pin_dis = 1'b0;
    pin_n = 1'b0;
    wait_n(1); chk("R9 hold before second edge", hold, 1'b0);
    wait_n(1); chk("R9 hold after second edge", hold, 1'b1);
    wait_n(6); chk("R5 locked no entry", prog, 1'b0);
    pin_n = 1'b1;
    wait_n(3); chk("R5 locked still idle", prog, 1'b0);
  endtask

  task automatic t_normal_entry;
    isp_en = 1'b1; pin_dis = 1'b0;
    power_up(1'b1);
    wait_n(6);
    chk("R3 normal prog", prog, 1'b0);
    chk("R3 normal hold", hold, 1'b0);
    pin_n = 1'b0;
    wait_n(2); chk("R6 prog before third edge", prog, 1'b0);
    wait_n(1); chk("R6 prog after third edge", prog, 1'b1);
    t_exit();
  endtask

  task automatic t_no_fuse;
    isp_en = 1'b0; pin_dis = 1'b0;
    power_up(1'b1);
    wait_n(5);
    pin_n = 1'b0;
    wait_n(8);
    chk("R7 no entry without fuse", prog, 1'b0);
    chk("R9 hold follows pin", hold, 1'b1);
    pin_n = 1'b1;
    wait_n(3);
  endtask

  task automatic t_pin_io;
    isp_en = 1'b1; pin_dis = 1'b1;
    power_up(1'b1);
    wait_n(5);
    pin_n = 1'b0;
    wait_n(8);
    chk("R8 no entry pin as io", prog, 1'b0);
    chk("R8 no hold pin as io", hold, 1'b0);
    pin_n = 1'b1;
    wait_n(3);
  endtask

  initial begin
    #1;
    chk("R1 prog at start", prog, 1'b0);
    chk("R1 hold at start", hold, 1'b1);
    t_por_entry(1'b0);
    t_exit();
    t_locked();
    // R10: fresh power-on reset after lock allows a session again
    t_por_entry(1'b1);
    t_exit();
    t_normal_entry();
    t_no_fuse();
    t_pin_io();
    wait_n(2);
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    #200000;
    if (!done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule